// File: doc/BRIEF.md
# Delta-Sigma Modulator Interface Controller

This block sits between a one-bit delta-sigma modulator and its decimation filter. It runs on the master clock (nominally 32.768 MHz) and produces the modulator clock by dividing that clock by 16 (normal rate, 2.048 MHz) or by 32 (low-power rate, 1.024 MHz). The modulator clock is off and held low after reset until its enable bit is set.

A rising edge on the asynchronous network sync input passes through a two-flop synchronizer. When sync is enabled, that edge restarts the clock divider and the bit-sample counter and emits a sync pulse to the modulator that lasts one modulator clock period. Every node that sees the same sync edge therefore samples on the same master-clock phase.

The incoming bitstream (one bit per 64 master clocks) and the over-range flag are captured together at a fixed master-clock offset after a modulator clock rising edge. Each captured pair is presented with a one-cycle valid strobe.

Top module: `dsm_if_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `mclk_o`, `msync_o` and `valid_o` are 0, and the modulator clock stays disabled until `cfg_clk_en_i` is set.
- R2: With the clock enabled and `cfg_rate_slow_i`=0, `mclk_o` has a period of DIV_FAST (16) master clocks and is high for the first half of each period.
- R3: With the clock enabled and `cfg_rate_slow_i`=1, `mclk_o` has a period of DIV_SLOW (32) master clocks and is high for the first half.
- R4: Enable and rate changes take effect only at a bit boundary, while `mclk_o` is low. Without a sync event, every high or low run of `mclk_o` lasts exactly half of one of the two periods (8 or 16 cycles).
- R5: With `cfg_sync_en_i`=1, a rising edge of `sync_i` driven just after a clock edge shows up as `msync_o`=1 after the third following edge. `msync_o` then stays high for one full modulator clock period, and `mclk_o` starts a fresh high phase in the same cycle that `msync_o` rises.
- R6: With `cfg_sync_en_i`=0, edges on `sync_i` produce no `msync_o` pulse.
- R7: `mdata_i` is captured SAMPLE_OFS (4) cycles after the cycle in which `mclk_o` starts the bit period. `valid_o` is high for exactly one cycle, SAMPLE_OFS+1 cycles after that start, with `bit_o` holding the captured value.
- R8: Valid strobes repeat every BIT_CYCLES (64) master clocks at both rates. That is four `mclk_o` periods per bit at the fast rate and two at the slow rate.
- R9: `flag_o` carries the `mflag_i` value captured in the same cycle as `bit_o`.
- R10: While the clock is disabled, `mclk_o` stays low, no `valid_o` strobe is issued and the bit-sample counter is held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_clk_en_i | input | 1 | Modulator clock enable |
| cfg_rate_slow_i | input | 1 | 1 selects the divide-by-32 low-power rate |
| cfg_sync_en_i | input | 1 | Allows sync_i edges to realign and pulse msync_o |
| sync_i | input | 1 | Asynchronous network sync input |
| mdata_i | input | 1 | Modulator bitstream |
| mflag_i | input | 1 | Modulator over-range flag |
| mclk_o | output | 1 | Modulator clock |
| msync_o | output | 1 | Sync pulse to the modulator |
| bit_o | output | 1 | Captured data bit |
| flag_o | output | 1 | Captured over-range flag |
| valid_o | output | 1 | One-cycle strobe for bit_o and flag_o |

## Verification
The bench builds the block with its default parameters: ratios 16 and 32, a 64-cycle bit period and a capture offset of 4. With these values both divide ratios, and the resulting four-versus-two clock periods per bit, are reached within a few hundred cycles per stimulus row. Each row realigns the block with a sync edge, then measures the sync latency, pulse length, clock high time, strobe position and spacing, and captured bit and flag relative to the first cycle of the sync pulse. Rate switches between rows are watched for shortened clock phases.

// File: rtl/dsm_if_pkg.sv
package dsm_if_pkg;
  typedef struct packed {
    logic en;
    logic slow;
  } clk_cfg_t;
endpackage

// File: rtl/dsm_sync_edge.sv
module dsm_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  input  logic en_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], async_i};
  end

  assign rise_o = en_i & sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/dsm_clk_div.sv
module dsm_clk_div
  import dsm_if_pkg::*;
#(
  parameter int DIV_FAST = 16,
  parameter int DIV_SLOW = 32,
  parameter int DIV_W    = $clog2(DIV_SLOW)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  clk_cfg_t       cfg_i,
  input  logic           apply_ok_i,
  input  logic           resync_i,
  output logic           mclk_o,
  output clk_cfg_t       act_o,
  output logic [DIV_W-1:0] cnt_o,
  output logic [DIV_W:0] period_o
);
  localparam logic [DIV_W-1:0] LAST_F = DIV_W'(DIV_FAST - 1);
  localparam logic [DIV_W-1:0] LAST_S = DIV_W'(DIV_SLOW - 1);
  localparam logic [DIV_W-1:0] HALF_F = DIV_W'(DIV_FAST / 2);
  localparam logic [DIV_W-1:0] HALF_S = DIV_W'(DIV_SLOW / 2);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  clk_cfg_t         act_q, act_d;
  logic             mclk_q, wrap;

  assign wrap = (cnt_q == (act_q.slow ? LAST_S : LAST_F));

  always_comb begin
    act_d = act_q;
    if (resync_i)  cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
    // new settings only at a period end (low phase) that the sampler allows
    if (wrap && apply_ok_i && !resync_i) act_d = cfg_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      act_q  <= '0;
      mclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      act_q  <= act_d;
      mclk_q <= act_d.en && (cnt_d < (act_d.slow ? HALF_S : HALF_F));
    end
  end

  assign mclk_o   = mclk_q;
  assign act_o    = act_q;
  assign cnt_o    = cnt_q;
  assign period_o = act_q.slow ? (DIV_W+1)'(DIV_SLOW) : (DIV_W+1)'(DIV_FAST);
endmodule

// File: rtl/dsm_bit_sampler.sv
module dsm_bit_sampler #(
  parameter int BIT_CYCLES = 64,
  parameter int SAMPLE_OFS = 4,
  parameter int SMP_W      = $clog2(BIT_CYCLES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             resync_i,
  input  logic             mdata_i,
  input  logic             mflag_i,
  output logic             bit_o,
  output logic             flag_o,
  output logic             valid_o,
  output logic             last_o,
  output logic [SMP_W-1:0] cnt_o
);
  localparam logic [SMP_W-1:0] LAST = SMP_W'(BIT_CYCLES - 1);
  localparam logic [SMP_W-1:0] OFS  = SMP_W'(SAMPLE_OFS);

  logic [SMP_W-1:0] cnt_q;
  logic             bit_q, flag_q, valid_q, capture;

  assign capture = run_i && !resync_i && (cnt_q == OFS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      bit_q   <= 1'b0;
      flag_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      if (!run_i || resync_i) cnt_q <= '0;
      else if (cnt_q == LAST) cnt_q <= '0;
      else                    cnt_q <= cnt_q + 1'b1;
      valid_q <= capture;
      if (capture) begin
        bit_q  <= mdata_i;
        flag_q <= mflag_i;
      end
    end
  end

  assign bit_o   = bit_q;
  assign flag_o  = flag_q;
  assign valid_o = valid_q;
  assign last_o  = (cnt_q == LAST);
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/dsm_if_ctrl.sv
module dsm_if_ctrl
  import dsm_if_pkg::*;
#(
  parameter int DIV_FAST   = 16,
  parameter int DIV_SLOW   = 32,
  parameter int BIT_CYCLES = 64,
  parameter int SAMPLE_OFS = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cfg_clk_en_i,
  input  logic cfg_rate_slow_i,
  input  logic cfg_sync_en_i,
  input  logic sync_i,
  input  logic mdata_i,
  input  logic mflag_i,
  output logic mclk_o,
  output logic msync_o,
  output logic bit_o,
  output logic flag_o,
  output logic valid_o
);
  localparam int DIV_W = $clog2(DIV_SLOW);
  localparam int SMP_W = $clog2(BIT_CYCLES);

  logic             resync, smp_last, apply_ok;
  clk_cfg_t         cfg, act;
  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W:0]   period, msync_cnt_q;
  logic [SMP_W-1:0] smp_cnt;

  assign cfg      = '{en: cfg_clk_en_i, slow: cfg_rate_slow_i};
  // while running, settings change only where a bit period ends
  assign apply_ok = !act.en || smp_last;

  dsm_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .async_i(sync_i), .en_i(cfg_sync_en_i), .rise_o(resync)
  );

  dsm_clk_div #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW), .DIV_W(DIV_W)) u_div (
    .clk_i, .rst_ni, .cfg_i(cfg), .apply_ok_i(apply_ok), .resync_i(resync),
    .mclk_o, .act_o(act), .cnt_o(div_cnt), .period_o(period)
  );

  dsm_bit_sampler #(.BIT_CYCLES(BIT_CYCLES), .SAMPLE_OFS(SAMPLE_OFS), .SMP_W(SMP_W)) u_smp (
    .clk_i, .rst_ni, .run_i(act.en), .resync_i(resync), .mdata_i, .mflag_i,
    .bit_o, .flag_o, .valid_o, .last_o(smp_last), .cnt_o(smp_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               msync_cnt_q <= '0;
    else if (resync)           msync_cnt_q <= period;
    else if (msync_cnt_q != 0) msync_cnt_q <= msync_cnt_q - 1'b1;
  end

  assign msync_o = (msync_cnt_q != 0);
endmodule

// File: rtl/dsm_if_ctrl_chk.sv
module dsm_if_ctrl_chk #(
  parameter int DIV_W      = 5,
  parameter int SMP_W      = 6,
  parameter int SAMPLE_OFS = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_sync_en_i,
  input logic             mclk_o,
  input logic             msync_o,
  input logic             valid_o,
  input logic             act_en,
  input logic             act_slow,
  input logic [DIV_W-1:0] div_cnt,
  input logic [SMP_W-1:0] smp_cnt
);
  localparam logic [SMP_W-1:0] VPH = SMP_W'(SAMPLE_OFS + 1);

  AST_MSYNC_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(msync_o) |-> $past(cfg_sync_en_i)); // R6
  AST_MSYNC_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(msync_o) |-> (div_cnt == '0 && smp_cnt == '0)); // R5
  AST_VALID_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R7
  AST_VALID_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> smp_cnt == VPH); // R7
  AST_HOLD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_en |-> smp_cnt == '0); // R10
  AST_OFF_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_en |-> !mclk_o && !valid_o); // R10
  AST_CFG_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(act_slow) || !$stable(act_en)) |-> !$past(mclk_o)); // R4
endmodule

bind dsm_if_ctrl dsm_if_ctrl_chk #(.DIV_W(DIV_W), .SMP_W(SMP_W), .SAMPLE_OFS(SAMPLE_OFS)) u_chk (
  .clk_i, .rst_ni, .cfg_sync_en_i, .mclk_o, .msync_o, .valid_o,
  .act_en(act.en), .act_slow(act.slow), .div_cnt(div_cnt), .smp_cnt(smp_cnt)
);

// File: tb/tb_dsm_if_ctrl.sv
`timescale 1ns/1ps
module tb_dsm_if_ctrl;
  localparam int OFS = 4;
  localparam int BITC = 64;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cfg_en = 0, cfg_slow = 0, cfg_sen = 0, sync = 0, mdata = 0, mflag = 0;
  logic mclk, msync, bit_v, flag_v, valid;
  int errors = 0, checks = 0;
  logic mon_en = 0;

  always #4 clk = ~clk;

  dsm_if_ctrl dut (
    .clk_i(clk), .rst_ni, .cfg_clk_en_i(cfg_en), .cfg_rate_slow_i(cfg_slow),
    .cfg_sync_en_i(cfg_sen), .sync_i(sync), .mdata_i(mdata), .mflag_i(mflag),
    .mclk_o(mclk), .msync_o(msync), .bit_o(bit_v), .flag_o(flag_v), .valid_o(valid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R4 run-length monitor
  logic mon_prev = 0, mon_seen = 0;
  int   mon_run = 0;
  always @(negedge clk) begin
    if (!mon_en) begin
      mon_seen <= 0; mon_run <= 0; mon_prev <= mclk;
    end else begin
      if (mclk != mon_prev) begin
        if (mon_seen) chk(mon_run == 8 || mon_run == 16, "R4 run length", mon_run, 8);
        mon_seen <= 1; mon_run <= 1;
      end else mon_run <= mon_run + 1;
      mon_prev <= mclk;
    end
  end

  // stimulus rows: {slow, mdata, mflag}
  localparam logic [2:0] VEC [4] = '{3'b010, 3'b001, 3'b111, 3'b100};

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    chk(mclk == 0 && msync == 0 && valid == 0, "R1 in reset", {mclk, msync, valid}, 0);
    rst_ni = 1;
    begin
      int seen = 0;
      for (int i = 0; i < 150; i++) begin
        @(negedge clk);
        if (mclk || valid || msync) seen++;
      end
      chk(seen == 0, "R1 idle after reset", seen, 0);
    end

    foreach (VEC[r]) begin
      int n, v1, v2, rises, mlen, mhi;
      logic b1, f1, hi_run;
      n = VEC[r][2] ? 32 : 16;
      cfg_en = 1; cfg_sen = 1; cfg_slow = VEC[r][2];
      mdata = VEC[r][1]; mflag = VEC[r][0];
      mon_en = 1;
      repeat (140) @(negedge clk);
      mon_en = 0;
      sync = 1; lat = 0;
      while (!msync && lat < 20) begin @(negedge clk); lat++; end
      sync = 0;
      chk(lat == 3, "R5 sync latency", lat, 3);
      chk(mclk == 1, "R5 mclk rises with msync", mclk, 1);
      v1 = -1; v2 = -1; rises = 0; mlen = 0; mhi = 0; hi_run = 1; b1 = 0; f1 = 0;
      for (int i = 0; i < 140; i++) begin
        if (msync) mlen++;
        if (hi_run && mclk) mhi++; else hi_run = 0;
        if (valid) begin
          if (v1 < 0) begin v1 = i; b1 = bit_v; f1 = flag_v; end
          else if (v2 < 0) v2 = i;
        end
        @(negedge clk);
        if (v1 >= 0 && v2 < 0 && mclk && i >= 0) ;
      end
      chk(mlen == n, "R5 msync length", mlen, n);
      if (VEC[r][2]) chk(mhi == 16, "R3 slow high time", mhi, 16);
      else           chk(mhi == 8, "R2 fast high time", mhi, 8);
      chk(v1 == OFS + 1, "R7 strobe position", v1, OFS + 1);
      chk(v2 - v1 == BITC, "R8 strobe spacing", v2 - v1, BITC);
      rises = 0;
      for (int k = v1 + 1; k <= v2; k++) if (k % n == 0) rises++;
      chk(rises == BITC / n, "R8 clock periods per bit", rises, BITC / n);
      chk(b1 == VEC[r][1], "R7 captured bit", b1, VEC[r][1]);
      chk(f1 == VEC[r][0], "R9 captured flag", f1, VEC[r][0]);
    end

    // R8 periods per bit observed directly at the pins (slow rate is active)
    begin
      int rises = 0, st = 0;
      logic pm = 0;
      while (!valid) @(negedge clk);
      @(negedge clk); pm = mclk;
      while (!valid) begin
        @(negedge clk);
        if (mclk && !pm) rises++;
        pm = mclk;
        st++;
        if (st > 200) break;
      end
      chk(rises == 2, "R8 slow rises between strobes", rises, 2);
    end

    // R6: sync ignored when disabled
    cfg_sen = 0;
    @(negedge clk); sync = 1;
    begin
      int seen = 0;
      for (int i = 0; i < 100; i++) begin @(negedge clk); if (msync) seen++; end
      chk(seen == 0, "R6 no msync when disabled", seen, 0);
    end
    sync = 0;

    // R10: clock disable
    cfg_en = 0;
    repeat (100) @(negedge clk);
    begin
      int seen = 0;
      for (int i = 0; i < 200; i++) begin @(negedge clk); if (mclk || valid) seen++; end
      chk(seen == 0, "R10 off: no clock or strobe", seen, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule